// File: doc/BRIEF.md
# BISYNC Transmit Framer

This block turns a stream of buffered characters into a serial character-oriented synchronous line. Characters arrive one at a time over a valid/acknowledge handshake. Each character carries the flags of its buffer: end of buffer, last buffer of the message, append block check, and raise interrupt. The framer puts a SYN1, SYN2 pair in front of every message. It counts the message data into a CRC16 or longitudinal check and appends that check when the closing buffer asks for it. Between messages it keeps the line busy with sync pairs or all-ones idle.

Starvation is handled in two ways. When a buffer boundary inside an unfinished message finds no next character, the framer fills with SYN1 characters, or with DLE, SYN1 pairs in transparent mode, and this is not an error. When data runs dry inside a buffer, the message is aborted. The framer then sends a SYN1, SYN2 pair and switches to a recovery fill, and it reports an underrun in a status pulse. Per-buffer completion and interrupt pulses let software tag any mix of buffers.

Bits leave on `tx_bit`, one per cycle in which `bit_en` is high. A character slot opens every eighth enabled bit.

Top module: `bisync_tx_framer`

## Requirements
- R1: While `enable` is low, `tx_bit` is 1 and no character is acknowledged. When `enable` is raised, the first character starts on the first `bit_en` pulse.
- R2: With no message pending, the fill is SYN1, SYN2 pairs when `fill_idle`=0, and 8'hFF characters when `fill_idle`=1.
- R3: Every message starts with SYN1 then SYN2, followed by its first data character.
- R4: Characters are sent LSB first when `msb_first`=0 and MSB first when it is 1. `tx_bit` changes only on cycles after `bit_en` was high.
- R5: The block check follows the data only when the closing buffer has both last and bcs set. With `use_lrc`=0 it is CRC16: polynomial x^16+x^15+x^2+1, zero preset, LSB first, low byte sent first. With `use_lrc`=1 it is one byte, the XOR of the data. The check covers all data of the message and no SYN, DLE-fill or idle character.
- R6: A buffer that ends without last is followed directly by the next buffer's data, with no SYN pair and no block check.
- R7: `buf_done` pulses for one cycle when each buffer's final character is taken. `irq` pulses with it only if that character's irq flag is set.
- R8: After a last buffer, `stat_valid` pulses once with `stat_underrun`=0. The pulse comes after the block check if one is sent. Afterwards the fill of R2 resumes.
- R9: At a buffer boundary inside a message with no character ready, the framer sends repeated SYN1. In transparent mode it sends DLE, SYN1 pairs instead. No status is raised. Data resumes without a SYN pair.
- R10: If data is missing inside a buffer, the framer sends SYN1, SYN2 and pulses `stat_valid` with `stat_underrun`=1. It then fills with SYN1 (`ur_idle`=0) or 8'hFF (`ur_idle`=1) until new data arrives, which opens a new message.
- R11: In transparent mode a data character equal to `dle_char` is sent twice and counted once in the block check.
- R12: `chr_ack` pulses for one cycle for each character taken, and only when `chr_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Transmitter on |
| bit_en | input | 1 | One-cycle bit-clock enable |
| fill_idle | input | 1 | Fill between messages: 0 SYN pairs, 1 all-ones |
| transparent | input | 1 | Transparent mode (DLE doubling, DLE-SYN fill) |
| use_lrc | input | 1 | Block check: 0 CRC16, 1 LRC |
| ur_idle | input | 1 | Fill after underrun: 0 SYN1, 1 all-ones |
| msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| sync1 | input | 8 | First sync character |
| sync2 | input | 8 | Second sync character |
| dle_char | input | 8 | Data link escape character |
| chr_valid | input | 1 | Character available |
| chr_data | input | 8 | Character value |
| chr_eob | input | 1 | Character is the final one of its buffer |
| chr_last | input | 1 | Buffer closes the message |
| chr_bcs | input | 1 | Append block check after the message |
| chr_irq | input | 1 | Raise interrupt at buffer end |
| chr_ack | output | 1 | Character taken (one cycle) |
| tx_bit | output | 1 | Serial line |
| buf_done | output | 1 | Buffer finished (one cycle) |
| irq | output | 1 | Interrupt request (one cycle) |
| stat_valid | output | 1 | Status written (one cycle) |
| stat_underrun | output | 1 | Status: underrun inside a buffer |

## Verification
The hardest case to reach is the difference between the two starvation kinds. Both show up only as the valid line dropping, and they differ only in whether the previous taken character closed its buffer. The bench feeds characters from an array whose length it extends between character slots. A buffer that is cut short before its end flag gives the in-buffer underrun. A buffer that is closed without the last flag gives the boundary fill. The bench then extends the array to show whether the next data opens a new message or continues the old one.

// File: rtl/bisync_pkg.sv
package bisync_pkg;
  localparam int CW = 8;
  localparam int BW = 2 * CW;
  localparam logic [BW-1:0] CRC_POLY_REFL = 16'hA001;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_PRE2,
    ST_DATA,
    ST_UR2,
    ST_BCS1,
    ST_BCS2
  } seq_st_t;
endpackage

// File: rtl/bisync_ser.sv
module bisync_ser #(
  parameter int CW = bisync_pkg::CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          bit_en,
  input  logic          msb_first,
  input  logic [CW-1:0] load_char,
  output logic          slot,
  output logic          tx_bit
);
  localparam int IW = $clog2(CW);

  logic [IW-1:0] idx;
  logic [CW-1:0] sh;
  logic          rev;

  assign slot = enable && bit_en && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      sh     <= '0;
      rev    <= 1'b0;
      tx_bit <= 1'b1;
    end else if (!enable) begin
      idx    <= '0;
      tx_bit <= 1'b1;
    end else if (bit_en) begin
      if (idx == '0) begin
        sh     <= load_char;
        rev    <= msb_first;
        tx_bit <= msb_first ? load_char[CW-1] : load_char[0];
        idx    <= IW'(1);
      end else begin
        tx_bit <= rev ? sh[CW-1-int'(idx)] : sh[int'(idx)];
        idx    <= (int'(idx) == CW-1) ? '0 : idx + IW'(1);
      end
    end
  end
endmodule

// File: rtl/bisync_bcs.sv
module bisync_bcs #(
  parameter int                         CW   = bisync_pkg::CW,
  parameter int                         BW   = bisync_pkg::BW,
  parameter logic [bisync_pkg::BW-1:0] POLY = bisync_pkg::CRC_POLY_REFL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic [CW-1:0] din,
  output logic [BW-1:0] crc,
  output logic [CW-1:0] lrc
);
  function automatic logic [BW-1:0] crc_step(input logic [BW-1:0] c,
                                              input logic [CW-1:0] d);
    logic [BW-1:0] r;
    logic          fb;
    r = c;
    for (int i = 0; i < CW; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ POLY[BW-1:0];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc <= '0;
      lrc <= '0;
    end else if (upd) begin
      crc <= crc_step(crc, din);
      lrc <= lrc ^ din;
    end
  end
endmodule

// File: rtl/bisync_seq.sv
module bisync_seq
  import bisync_pkg::*;
#(
  parameter int CW = bisync_pkg::CW,
  parameter int BW = bisync_pkg::BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          slot,
  input  logic          fill_idle,
  input  logic          transparent,
  input  logic          use_lrc,
  input  logic          ur_idle,
  input  logic [CW-1:0] sync1,
  input  logic [CW-1:0] sync2,
  input  logic [CW-1:0] dle_char,
  input  logic          chr_valid,
  input  logic [CW-1:0] chr_data,
  input  logic          chr_eob,
  input  logic          chr_last,
  input  logic          chr_bcs,
  input  logic          chr_irq,
  input  logic [BW-1:0] crc,
  input  logic [CW-1:0] lrc,
  output logic [CW-1:0] ch,
  output logic          acc_clear,
  output logic          acc_upd,
  output logic          chr_ack,
  output logic          buf_done,
  output logic          irq,
  output logic          stat_valid,
  output logic          stat_underrun
);
  seq_st_t st, n_st;
  logic phase, n_phase;
  logic between, n_between;
  logic ur_flag, n_ur;
  logic dle_dup, n_dup;
  logic take, clr, upd, done_p, irq_p, stv_p, stu_p;

  always_comb begin
    ch        = '1;
    n_st      = st;
    n_phase   = phase;
    n_between = between;
    n_ur      = ur_flag;
    n_dup     = dle_dup;
    take      = 1'b0;
    clr       = 1'b0;
    upd       = 1'b0;
    done_p    = 1'b0;
    irq_p     = 1'b0;
    stv_p     = 1'b0;
    stu_p     = 1'b0;
    if (dle_dup) begin
      ch    = dle_char;
      n_dup = 1'b0;
    end else begin
      unique case (st)
        ST_FILL: begin
          if (phase) begin
            ch      = sync2;
            n_phase = 1'b0;
          end else if (chr_valid) begin
            ch        = sync1;
            n_st      = ST_PRE2;
            clr       = 1'b1;
            n_ur      = 1'b0;
            n_between = 1'b0;
          end else if (ur_flag) begin
            ch = ur_idle ? '1 : sync1;
          end else if (fill_idle) begin
            ch = '1;
          end else begin
            ch      = sync1;
            n_phase = 1'b1;
          end
        end
        ST_PRE2: begin
          ch   = sync2;
          n_st = ST_DATA;
        end
        ST_DATA: begin
          if (phase) begin
            ch      = sync1;
            n_phase = 1'b0;
          end else if (chr_valid) begin
            ch        = chr_data;
            take      = 1'b1;
            upd       = 1'b1;
            n_between = 1'b0;
            if (transparent && (chr_data == dle_char)) n_dup = 1'b1;
            if (chr_eob) begin
              done_p = 1'b1;
              irq_p  = chr_irq;
              if (chr_last) begin
                if (chr_bcs) begin
                  n_st = ST_BCS1;
                end else begin
                  n_st  = ST_FILL;
                  stv_p = 1'b1;
                end
              end else begin
                n_between = 1'b1;
              end
            end
          end else if (between) begin
            if (transparent) begin
              ch      = dle_char;
              n_phase = 1'b1;
            end else begin
              ch = sync1;
            end
          end else begin
            ch    = sync1;
            n_st  = ST_UR2;
            stv_p = 1'b1;
            stu_p = 1'b1;
            n_ur  = 1'b1;
          end
        end
        ST_UR2: begin
          ch   = sync2;
          n_st = ST_FILL;
        end
        ST_BCS1: begin
          ch = use_lrc ? lrc : crc[CW-1:0];
          if (use_lrc) begin
            n_st  = ST_FILL;
            stv_p = 1'b1;
          end else begin
            n_st = ST_BCS2;
          end
        end
        ST_BCS2: begin
          ch    = crc[BW-1:CW];
          n_st  = ST_FILL;
          stv_p = 1'b1;
        end
        default: n_st = ST_FILL;
      endcase
    end
  end

  assign acc_clear = slot && clr;
  assign acc_upd   = slot && upd;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st            <= ST_FILL;
      phase         <= 1'b0;
      between       <= 1'b0;
      ur_flag       <= 1'b0;
      dle_dup       <= 1'b0;
      chr_ack       <= 1'b0;
      buf_done      <= 1'b0;
      irq           <= 1'b0;
      stat_valid    <= 1'b0;
      stat_underrun <= 1'b0;
    end else begin
      chr_ack       <= slot && take;
      buf_done      <= slot && done_p;
      irq           <= slot && irq_p;
      stat_valid    <= slot && stv_p;
      stat_underrun <= slot && stu_p;
      if (slot) begin
        st      <= n_st;
        phase   <= n_phase;
        between <= n_between;
        ur_flag <= n_ur;
        dle_dup <= n_dup;
      end
    end
  end
endmodule

// File: rtl/bisync_tx_framer.sv
module bisync_tx_framer #(
  parameter int CHAR_W = bisync_pkg::CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              bit_en,
  input  logic              fill_idle,
  input  logic              transparent,
  input  logic              use_lrc,
  input  logic              ur_idle,
  input  logic              msb_first,
  input  logic [CHAR_W-1:0] sync1,
  input  logic [CHAR_W-1:0] sync2,
  input  logic [CHAR_W-1:0] dle_char,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              chr_eob,
  input  logic              chr_last,
  input  logic              chr_bcs,
  input  logic              chr_irq,
  output logic              chr_ack,
  output logic              tx_bit,
  output logic              buf_done,
  output logic              irq,
  output logic              stat_valid,
  output logic              stat_underrun
);
  localparam int BCS_W = 2 * CHAR_W;

  logic              slot;
  logic [CHAR_W-1:0] ch;
  logic              acc_clear, acc_upd;
  logic [BCS_W-1:0]  crc;
  logic [CHAR_W-1:0] lrc;

  bisync_ser #(.CW(CHAR_W)) u_ser (
    .clk(clk), .rst(rst), .enable(enable), .bit_en(bit_en),
    .msb_first(msb_first), .load_char(ch), .slot(slot), .tx_bit(tx_bit)
  );

  bisync_bcs #(.CW(CHAR_W), .BW(BCS_W)) u_bcs (
    .clk(clk), .rst(rst), .clear(acc_clear), .upd(acc_upd),
    .din(chr_data), .crc(crc), .lrc(lrc)
  );

  bisync_seq #(.CW(CHAR_W), .BW(BCS_W)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .slot(slot),
    .fill_idle(fill_idle), .transparent(transparent), .use_lrc(use_lrc),
    .ur_idle(ur_idle), .sync1(sync1), .sync2(sync2), .dle_char(dle_char),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_eob(chr_eob),
    .chr_last(chr_last), .chr_bcs(chr_bcs), .chr_irq(chr_irq),
    .crc(crc), .lrc(lrc), .ch(ch), .acc_clear(acc_clear), .acc_upd(acc_upd),
    .chr_ack(chr_ack), .buf_done(buf_done), .irq(irq),
    .stat_valid(stat_valid), .stat_underrun(stat_underrun)
  );
endmodule

// File: rtl/bisync_tx_framer_chk.sv
module bisync_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic bit_en,
  input logic chr_valid,
  input logic chr_ack,
  input logic tx_bit,
  input logic buf_done,
  input logic irq,
  input logic stat_valid,
  input logic stat_underrun
);
  // R12: a take needs a valid character and lasts one cycle
  assert_ack_needs_valid_R12: assert property (@(posedge clk) disable iff (rst)
    chr_ack |-> $past(chr_valid));
  assert_ack_single_R12: assert property (@(posedge clk) disable iff (rst)
    chr_ack |=> !chr_ack);
  // R7: interrupt only together with a buffer end
  assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> buf_done);
  // R10: underrun flag only inside a status pulse
  assert_underrun_in_status_R10: assert property (@(posedge clk) disable iff (rst)
    stat_underrun |-> stat_valid);
  // R1: disabled line rests high
  assert_off_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> tx_bit);
  // R4: line moves only on bit enables
  assert_line_held_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_en) && $past(enable)) |-> $stable(tx_bit));
endmodule

bind bisync_tx_framer bisync_tx_framer_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .bit_en(bit_en),
  .chr_valid(chr_valid), .chr_ack(chr_ack), .tx_bit(tx_bit),
  .buf_done(buf_done), .irq(irq), .stat_valid(stat_valid),
  .stat_underrun(stat_underrun)
);

// File: tb/bisync_tx_framer_bench.sv
module bisync_tx_framer_bench;
  localparam logic [7:0] S1  = 8'h67;
  localparam logic [7:0] S2  = 8'h3C;
  localparam logic [7:0] DLE = 8'h10;

  typedef struct packed {
    logic [31:0] d;
    logic [2:0]  n;
    logic        bcs;
    logic        lrc;
    logic        tr;
    logic        msb;
    logic        idl;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h00434241, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h00434241, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h00005510, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h000001A5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h00000281, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'h00000000, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, bit_en = 1'b0;
  logic fill_idle = 1'b0, transparent = 1'b0, use_lrc = 1'b0;
  logic ur_idle = 1'b0, msb_first = 1'b0;
  logic chr_valid, chr_eob, chr_last, chr_bcs, chr_irq;
  logic [7:0] chr_data;
  logic chr_ack, tx_bit, buf_done, irq, stat_valid, stat_underrun;

  logic [7:0] s_d [16];
  logic       s_eob [16], s_last [16], s_bcs [16], s_irq [16];
  int s_len = 0, s_ptr = 0;
  logic [7:0] m [16];
  int m_n = 0;
  logic [7:0] exp_b [32];
  int exp_n = 0;
  int n_chk = 0, n_err = 0;
  int n_done = 0, n_irq = 0, n_stat = 0, n_ur = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign chr_valid = (s_ptr < s_len);
  assign chr_data  = s_d[s_ptr % 16];
  assign chr_eob   = s_eob[s_ptr % 16];
  assign chr_last  = s_last[s_ptr % 16];
  assign chr_bcs   = s_bcs[s_ptr % 16];
  assign chr_irq   = s_irq[s_ptr % 16];

  bisync_tx_framer u_bisync_tx_framer (
    .clk(clk), .rst(rst), .enable(enable), .bit_en(bit_en),
    .fill_idle(fill_idle), .transparent(transparent), .use_lrc(use_lrc),
    .ur_idle(ur_idle), .msb_first(msb_first), .sync1(S1), .sync2(S2),
    .dle_char(DLE), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_eob(chr_eob), .chr_last(chr_last), .chr_bcs(chr_bcs),
    .chr_irq(chr_irq), .chr_ack(chr_ack), .tx_bit(tx_bit),
    .buf_done(buf_done), .irq(irq), .stat_valid(stat_valid),
    .stat_underrun(stat_underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(output logic b);
    bit_en = 1'b1;
    @(posedge clk);
    #1;
    bit_en = 1'b0;
    b = tx_bit;
    if (chr_ack) s_ptr++;
    if (buf_done) n_done++;
    if (irq) n_irq++;
    if (stat_valid) begin
      n_stat++;
      if (stat_underrun) n_ur++;
    end
  endtask

  task automatic get_char(output logic [7:0] c);
    logic b;
    for (int i = 0; i < 8; i++) begin
      step(b);
      if (msb_first) c[7-i] = b; else c[i] = b;
    end
  endtask

  task automatic add_chr(input logic [7:0] d, input logic eob, input logic last,
                         input logic bcs, input logic irqf);
    s_d[s_len % 16] = d; s_eob[s_len % 16] = eob; s_last[s_len % 16] = last;
    s_bcs[s_len % 16] = bcs; s_irq[s_len % 16] = irqf;
    s_len++;
    m[m_n % 16] = d; m_n++;
  endtask

  task automatic push(input logic [7:0] b);
    exp_b[exp_n % 32] = b;
    exp_n++;
  endtask

  task automatic expect_chars(input string req);
    logic [7:0] c;
    for (int i = 0; i < exp_n; i++) begin
      get_char(c);
      chk(req, {24'h0, c}, {24'h0, exp_b[i]});
    end
    exp_n = 0;
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] r = 16'h0;
    for (int i = 0; i < m_n; i++)
      for (int k = 0; k < 8; k++)
        if ((r[0] ^ m[i][k]) == 1'b1) r = (r >> 1) ^ 16'hA001;
        else r = r >> 1;
    return r;
  endfunction

  function automatic logic [7:0] ref_lrc();
    logic [7:0] x = 8'h0;
    for (int i = 0; i < m_n; i++) x ^= m[i];
    return x;
  endfunction

  task automatic push_crc();
    logic [15:0] r;
    r = ref_crc();
    push(r[7:0]);
    push(r[15:8]);
  endtask

  task automatic restart();
    logic b;
    enable = 1'b0;
    step(b); step(b);
    s_len = 0; s_ptr = 0; m_n = 0; exp_n = 0;
    n_done = 0; n_irq = 0; n_stat = 0; n_ur = 0;
    fill_idle = 0; transparent = 0; use_lrc = 0; ur_idle = 0; msb_first = 0;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic b, held;
    int ones;
    for (int i = 0; i < 16; i++) begin
      s_d[i] = 0; s_eob[i] = 0; s_last[i] = 0; s_bcs[i] = 0; s_irq[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // reset state
    chk("R1 reset tx", {31'h0, tx_bit}, 1);
    chk("R12 reset ack", {31'h0, chr_ack}, 0);
    chk("R8 reset status", {31'h0, stat_valid}, 0);

    // vector table walk: one whole message per entry
    for (int v = 0; v < 6; v++) begin
      restart();
      use_lrc = VEC[v].lrc; transparent = VEC[v].tr;
      msb_first = VEC[v].msb; fill_idle = VEC[v].idl;
      m_n = 0;
      push(S1); push(S2);
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        logic [7:0] d;
        d = VEC[v].d[8*i +: 8];
        add_chr(d, i == int'(VEC[v].n) - 1, 1'b1, VEC[v].bcs, 1'b1);
        push(d);
        if (VEC[v].tr && d == DLE) push(d);
      end
      if (VEC[v].bcs) begin
        if (VEC[v].lrc) push(ref_lrc()); else push_crc();
      end
      if (VEC[v].idl) begin push(8'hFF); push(8'hFF); end
      else begin push(S1); push(S2); end
      enable = 1'b1;
      expect_chars("R3 R4 R5 R11 R2 message stream");
      chk("R8 status count", n_stat, 1);
      chk("R8 no underrun", n_ur, 0);
      chk("R7 irq count", n_irq, 1);
      chk("R12 all taken", s_ptr, s_len);
    end

    // R2: pure fill in both modes
    restart();
    enable = 1'b1;
    push(S1); push(S2); push(S1); push(S2);
    expect_chars("R2 sync pair fill");
    restart();
    fill_idle = 1'b1; enable = 1'b1;
    push(8'hFF); push(8'hFF);
    expect_chars("R2 idle fill");

    // R1: disabled with data waiting
    restart();
    add_chr(8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    ones = 0;
    for (int i = 0; i < 12; i++) begin step(b); ones += int'(b); end
    chk("R1 line high while off", ones, 12);
    chk("R1 nothing taken while off", s_ptr, 0);

    // R4: line held without bit enable
    restart();
    enable = 1'b1;
    step(b); step(b); step(b);
    held = tx_bit;
    for (int i = 0; i < 6; i++) begin @(posedge clk); #1; chk("R4 held without bit_en", {31'h0, tx_bit}, {31'h0, held}); end

    // R6 R7: multibuffer message, interrupt on second buffer only
    restart();
    add_chr(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    add_chr(8'h22, 1'b1, 1'b0, 1'b0, 1'b0);
    add_chr(8'h33, 1'b1, 1'b1, 1'b1, 1'b1);
    push(S1); push(S2); push(8'h11); push(8'h22); push(8'h33);
    push_crc(); push(S1); push(S2);
    enable = 1'b1;
    expect_chars("R6 multibuffer stream");
    chk("R7 done count", n_done, 2);
    chk("R7 irq count", n_irq, 1);
    chk("R8 status once", n_stat, 1);

    // R9: boundary starvation, plain mode
    restart();
    add_chr(8'h44, 1'b1, 1'b0, 1'b0, 1'b0);
    push(S1); push(S2); push(8'h44); push(S1); push(S1);
    enable = 1'b1;
    expect_chars("R9 boundary fill plain");
    chk("R9 no status", n_stat, 0);
    add_chr(8'h55, 1'b1, 1'b1, 1'b0, 1'b0);
    push(8'h55); push(S1); push(S2);
    expect_chars("R9 resume without pair");
    chk("R8 status after resume", n_stat, 1);
    chk("R9 no underrun", n_ur, 0);

    // R9 R11: boundary starvation, transparent mode
    restart();
    transparent = 1'b1;
    add_chr(8'h44, 1'b1, 1'b0, 1'b0, 1'b0);
    push(S1); push(S2); push(8'h44); push(DLE); push(S1); push(DLE); push(S1);
    enable = 1'b1;
    expect_chars("R9 boundary fill transparent");
    chk("R9 no status transparent", n_stat, 0);
    add_chr(8'h66, 1'b1, 1'b1, 1'b1, 1'b0);
    push(8'h66); push_crc(); push(S1); push(S2);
    expect_chars("R9 R5 resume and check");

    // R10: underrun inside a buffer, sync recovery then new message
    restart();
    add_chr(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    push(S1); push(S2); push(8'h77); push(S1); push(S2); push(S1); push(S1);
    enable = 1'b1;
    expect_chars("R10 underrun sync recovery");
    chk("R10 underrun status", n_ur, 1);
    chk("R10 status pulses", n_stat, 1);
    add_chr(8'h78, 1'b1, 1'b1, 1'b0, 1'b0);
    push(S1); push(S2); push(8'h78);
    expect_chars("R10 new message after underrun");

    // R10: idle recovery
    restart();
    ur_idle = 1'b1;
    add_chr(8'h79, 1'b0, 1'b0, 1'b0, 1'b0);
    push(S1); push(S2); push(8'h79); push(S1); push(S2); push(8'hFF); push(8'hFF);
    enable = 1'b1;
    expect_chars("R10 underrun idle recovery");
    chk("R10 underrun status idle", n_ur, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule